// File: doc/BRIEF.md
# Root-Port Legacy Interrupt Queue

This block is the interrupt register file of a PCIe root port. Downstream devices signal legacy interrupts as assert and deassert messages on four lanes. Each message arrives here as a one-cycle strobe carrying a lane number and a level, and the block stores it as a record in a small circular queue. Software drains the queue through a 32-bit register port. A read of a queue register returns the oldest record. A write to either queue register discards that record.

Next to the queue, the block holds a latched decode word and a mask word. It raises one level-sensitive interrupt line toward the host CPU when any decoded cause is also enabled. As long as the queue holds records, the legacy-interrupt cause stays set, so software cannot lose a pending message by acknowledging too early. The same port also exposes a link-up status bit and a bridge-enable control bit that gates the downstream memory window. It also shows a sticky flag for messages that were lost because the queue was full.

A read returns its data on `reg_rdata` at the clock edge that samples `reg_rd`. A write takes effect at the clock edge that samples `reg_wr`. `irq_out` and `bridge_en` are registers that change on the same edge as the state they reflect. Reset is synchronous and active high.

Top module: `rp_intx_ctrl`

## Requirements
- R1: After reset, every mapped register reads zero (with `link_up` low), and `irq_out` and `bridge_en` are low.
- R2: A queued record read at offset 0x158 has bit 31 set, the level (1 = assert) in bit 29 and the lane in bits 28:27, with all other bits zero. Offset 0x15C always reads zero.
- R3: Records leave the queue in arrival order. A write of any data to 0x158 or 0x15C removes the oldest record, and the queue pointers wrap around.
- R4: With the queue empty, 0x158 reads zero, and a write to 0x158 or 0x15C changes nothing: a record queued afterwards is the next one read.
- R5: The queue holds DEPTH-1 records. A message that arrives when the queue is full is dropped, and bit 19 of 0x148 becomes 1 and stays 1.
- R6: Writing 0x148 with bit 19 set clears the overflow flag, unless a drop happens in the same cycle.
- R7: Decode (0x138) bit 16 is set when a message is queued. Writing 1s to 0x138 clears those bits, but bit 16 stays set while the queue holds any record. Bit 17 is never set by this block.
- R8: Mask (0x13C) is a 32-bit read/write register. `irq_out` is 1 exactly when decode AND mask is nonzero, and it updates on the same edge as the decode or mask change.
- R9: Bit 0 of 0x148 is read/write and drives `bridge_en`.
- R10: Bit 18 of 0x148 reads 1 while the queue holds at least one record.
- R11: Bit 11 of 0x144 reads the current value of `link_up`. All other bits of 0x144 read zero.
- R12: Reads of any other offset return zero, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link-up status from the physical layer |
| msg_valid | input | 1 | One-cycle strobe: a legacy interrupt message arrived |
| msg_lane | input | 2 | Interrupt lane of the message (0 to 3) |
| msg_assert | input | 1 | 1 = assert message, 0 = deassert message |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered on the edge that samples reg_rd |
| irq_out | output | 1 | Level interrupt to the host CPU |
| bridge_en | output | 1 | Enable for the downstream memory window |

## Verification
The bench builds the block with DEPTH = 4, so the queue holds only three records. With that depth, a single fourth message reaches the full condition and the overflow flag. A few rounds of push and pop make both pointers wrap past the end of the storage several times. The default depth of 16 gives the same logic a wider pointer and is covered by the default elaboration.

// File: rtl/rp_intx_pkg.sv
package rp_intx_pkg;

  // register byte offsets
  localparam int OFS_DECODE = 'h138;
  localparam int OFS_MASK   = 'h13C;
  localparam int OFS_PHY    = 'h144;
  localparam int OFS_PORT   = 'h148;
  localparam int OFS_QWORD1 = 'h158;
  localparam int OFS_QWORD2 = 'h15C;

  // bit positions
  localparam int BIT_INTX      = 16;
  localparam int BIT_MSI       = 17;
  localparam int BIT_LINK      = 11;
  localparam int BIT_BRIDGE    = 0;
  localparam int BIT_NONEMPTY  = 18;
  localparam int BIT_OVERFLOW  = 19;

  typedef struct packed {
    logic       level;
    logic [1:0] lane;
  } intx_rec_t;

  function automatic logic [31:0] rec_word(input intx_rec_t r);
    return {1'b1, 1'b0, r.level, r.lane, 27'b0};
  endfunction

endpackage

// File: rtl/rp_intx_queue.sv
module rp_intx_queue
  import rp_intx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  intx_rec_t push_rec,
  input  logic      pop,
  output intx_rec_t head,
  output logic      empty,
  output logic      full,
  output logic      empty_nxt,
  output logic      drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  intx_rec_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_d, rd_d, wr_inc;
  logic             do_push, do_pop;

  always_comb begin
    wr_inc    = bump(wr_ptr);
    empty     = (wr_ptr == rd_ptr);
    full      = (wr_inc == rd_ptr);
    do_push   = push & ~full;
    do_pop    = pop & ~empty;
    drop      = push & full;
    wr_d      = do_push ? wr_inc : wr_ptr;
    rd_d      = do_pop ? bump(rd_ptr) : rd_ptr;
    empty_nxt = (wr_d == rd_d);
    head      = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_d;
      rd_ptr <= rd_d;
    end
  end

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_rec;
  end

endmodule

// File: rtl/rp_intx_status.sv
module rp_intx_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        pend_nxt,
  input  logic        clr_we,
  input  logic [1:0]  clr_bits,
  input  logic        mask_we,
  input  logic [31:0] mask_wdata,
  output logic [1:0]  dec_q,
  output logic [31:0] mask_q,
  output logic        irq
);
  logic [1:0]  dec_d;
  logic [31:0] mask_d;

  always_comb begin
    dec_d = dec_q & ~(clr_we ? clr_bits : 2'b00);
    if (pend_nxt) dec_d[0] = 1'b1;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q  <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      dec_q  <= dec_d;
      mask_q <= mask_d;
      irq    <= |(dec_d & mask_d[17:16]);
    end
  end

endmodule

// File: rtl/rp_intx_ctrl.sv
module rp_intx_ctrl
  import rp_intx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic              msg_valid,
  input  logic [1:0]        msg_lane,
  input  logic              msg_assert,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out,
  output logic              bridge_en
);
  localparam logic [ADDR_W-1:0] A_DEC  = ADDR_W'(OFS_DECODE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PHY  = ADDR_W'(OFS_PHY);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFS_PORT);
  localparam logic [ADDR_W-1:0] A_Q1   = ADDR_W'(OFS_QWORD1);
  localparam logic [ADDR_W-1:0] A_Q2   = ADDR_W'(OFS_QWORD2);

  intx_rec_t   in_rec, q_head;
  logic        q_empty, q_full, q_empty_nxt, q_drop, q_pop;
  logic        wr_dec, wr_mask, wr_port;
  logic [1:0]  dec_q;
  logic [31:0] mask_q, rd_mux;
  logic        ovf_q;

  assign in_rec  = '{level: msg_assert, lane: msg_lane};
  assign wr_dec  = reg_wr && (reg_addr == A_DEC);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_port = reg_wr && (reg_addr == A_PORT);
  assign q_pop   = reg_wr && ((reg_addr == A_Q1) || (reg_addr == A_Q2));

  rp_intx_queue #(.DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (msg_valid),
    .push_rec  (in_rec),
    .pop       (q_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full),
    .empty_nxt (q_empty_nxt),
    .drop      (q_drop)
  );

  rp_intx_status u_status (
    .clk        (clk),
    .rst        (rst),
    .pend_nxt   (~q_empty_nxt),
    .clr_we     (wr_dec),
    .clr_bits   (reg_wdata[BIT_MSI:BIT_INTX]),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata),
    .dec_q      (dec_q),
    .mask_q     (mask_q),
    .irq        (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q     <= 1'b0;
      bridge_en <= 1'b0;
    end else begin
      if (q_drop)                                 ovf_q <= 1'b1;
      else if (wr_port && reg_wdata[BIT_OVERFLOW]) ovf_q <= 1'b0;
      if (wr_port) bridge_en <= reg_wdata[BIT_BRIDGE];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_DEC:  rd_mux[BIT_MSI:BIT_INTX] = dec_q;
      A_MASK: rd_mux = mask_q;
      A_PHY:  rd_mux[BIT_LINK] = link_up;
      A_PORT: begin
        rd_mux[BIT_BRIDGE]   = bridge_en;
        rd_mux[BIT_NONEMPTY] = ~q_empty;
        rd_mux[BIT_OVERFLOW] = ovf_q;
      end
      A_Q1:   rd_mux = q_empty ? 32'h0 : rec_word(q_head);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/rp_intx_ctrl_chk.sv
module rp_intx_ctrl_chk
  import rp_intx_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_out,
  input logic              bridge_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit0,
  input logic              wbit19,
  input logic              ovf,
  input logic              drop,
  input logic              q_empty,
  input logic              q_full,
  input logic [1:0]        dec,
  input logic [1:0]        mask_hi
);
  logic port_wr;
  assign port_wr = reg_wr && (reg_addr == ADDR_W'(OFS_PORT));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_out && !bridge_en));

  a_r9_bridge_load: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> (bridge_en == $past(wbit0)));

  a_r9_bridge_hold: assert property (@(posedge clk) disable iff (rst)
    !port_wr |=> $stable(bridge_en));

  a_r5_drop_flags: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(port_wr && wbit19)) |=> ovf);

  a_r6_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (port_wr && wbit19 && !drop) |=> !ovf);

  a_r7_pending_intx: assert property (@(posedge clk) disable iff (rst)
    !q_empty |-> dec[0]);

  a_r7_no_msi: assert property (@(posedge clk) disable iff (rst)
    !dec[1]);

  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(dec & mask_hi));

  a_r5_empty_full_excl: assert property (@(posedge clk) disable iff (rst)
    !(q_empty && q_full));

endmodule

bind rp_intx_ctrl rp_intx_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .bridge_en (bridge_en),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wbit0     (reg_wdata[0]),
  .wbit19    (reg_wdata[19]),
  .ovf       (ovf_q),
  .drop      (q_drop),
  .q_empty   (q_empty),
  .q_full    (q_full),
  .dec       (dec_q),
  .mask_hi   (mask_q[17:16])
);

// File: tb/rp_intx_ctrl_bench.sv
module rp_intx_ctrl_bench;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 12;

  localparam logic [11:0] DEC = 12'h138, MSK = 12'h13C, PHY = 12'h144;
  localparam logic [11:0] PRT = 12'h148, Q1 = 12'h158, Q2 = 12'h15C;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              link_up = 1'b0;
  logic              msg_valid = 1'b0;
  logic [1:0]        msg_lane = '0;
  logic              msg_assert = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq_out, bridge_en;

  int tests = 0;
  int fails = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rp_intx_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rp_intx_ctrl (
    .clk(clk), .rst(rst), .link_up(link_up), .msg_valid(msg_valid),
    .msg_lane(msg_lane), .msg_assert(msg_assert), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .bridge_en(bridge_en)
  );

  function automatic logic [31:0] word1(input logic [1:0] lane, input logic lvl);
    return 32'h8000_0000 | (32'(lvl) << 29) | (32'(lane) << 27);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue the expectation, then issue the read
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic msg(input logic [1:0] lane, input logic lvl);
    @(negedge clk); msg_valid = 1'b1; msg_lane = lane; msg_assert = lvl;
    @(negedge clk); msg_valid = 1'b0;
  endtask

  // monitor: compare each read result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL monitor: unexpected read data %h expected none", reg_rdata);
        end else begin
          check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 bridge", {31'b0, bridge_en}, 32'h0);
    rd(DEC, 32'h0, "R1 decode");
    rd(MSK, 32'h0, "R1 mask");
    rd(PHY, 32'h0, "R1 phy");
    rd(PRT, 32'h0, "R1 port");
    rd(Q1,  32'h0, "R1 q1");
    rd(Q2,  32'h0, "R1 q2");

    // R11 link status
    link_up = 1'b1;
    rd(PHY, 32'h0000_0800, "R11 link up");
    link_up = 1'b0;
    rd(PHY, 32'h0, "R11 link down");

    // R8 mask read/write
    wr(MSK, 32'h0001_0000);
    rd(MSK, 32'h0001_0000, "R8 mask rw");
    check("R8 irq no cause", {31'b0, irq_out}, 32'h0);

    // R2 / R7 / R10 first message
    msg(2'd2, 1'b1);
    check("R8 irq raised", {31'b0, irq_out}, 32'h1);
    rd(Q1,  32'hB000_0000, "R2 word1");
    rd(Q2,  32'h0, "R2 word2");
    rd(DEC, 32'h0001_0000, "R7 decode set");
    rd(PRT, 32'h0004_0000, "R10 nonempty");

    // R7 clear while pending has no lasting effect
    wr(DEC, 32'h0003_0000);
    rd(DEC, 32'h0001_0000, "R7 clear while pending");
    check("R7 irq stays", {31'b0, irq_out}, 32'h1);

    // R5 fill and overflow (capacity DEPTH-1 = 3)
    msg(2'd1, 1'b0);
    msg(2'd3, 1'b1);
    msg(2'd0, 1'b1);
    rd(PRT, 32'h000C_0000, "R5 overflow set");

    // R3 ordering and pop through either register
    wr(Q1, 32'h0);
    rd(Q1, word1(2'd1, 1'b0), "R3 second record");
    wr(Q2, 32'hFFFF_FFFF);
    rd(Q1, word1(2'd3, 1'b1), "R3 third record");
    wr(Q1, 32'h0);
    rd(Q1,  32'h0, "R5 dropped record absent");
    rd(PRT, 32'h0008_0000, "R5 overflow sticky");

    // R4 pop on empty ignored
    wr(Q1, 32'h0);
    wr(Q2, 32'h0);
    rd(PRT, 32'h0008_0000, "R4 still empty");
    msg(2'd0, 1'b0);
    rd(Q1, word1(2'd0, 1'b0), "R4 next record after empty pop");
    wr(Q1, 32'h0);

    // R7 decode clears once drained
    rd(DEC, 32'h0001_0000, "R7 latched after drain");
    wr(DEC, 32'h0001_0000);
    rd(DEC, 32'h0, "R7 cleared");
    check("R8 irq dropped", {31'b0, irq_out}, 32'h0);

    // R6 overflow clear
    wr(PRT, 32'h0008_0000);
    rd(PRT, 32'h0, "R6 overflow cleared");

    // R9 bridge enable
    wr(PRT, 32'h0000_0001);
    check("R9 bridge on", {31'b0, bridge_en}, 32'h1);
    rd(PRT, 32'h0000_0001, "R9 bridge readback");
    wr(PRT, 32'h0008_0000);
    check("R9 bridge off", {31'b0, bridge_en}, 32'h0);

    // R8 masking
    msg(2'd1, 1'b1);
    check("R8 irq on", {31'b0, irq_out}, 32'h1);
    wr(MSK, 32'h0);
    check("R8 masked", {31'b0, irq_out}, 32'h0);
    wr(MSK, 32'h0002_0000);
    check("R8 other bit", {31'b0, irq_out}, 32'h0);
    wr(MSK, 32'h0001_0000);
    check("R8 unmasked", {31'b0, irq_out}, 32'h1);

    // R12 unmapped offsets
    wr(12'h140, 32'hFFFF_FFFF);
    wr(12'h13A, 32'hFFFF_FFFF);
    rd(12'h140, 32'h0, "R12 unmapped read");
    rd(MSK, 32'h0001_0000, "R12 mask untouched");
    rd(PRT, 32'h0004_0000, "R12 port untouched");
    rd(Q1, word1(2'd1, 1'b1), "R12 queue untouched");
    wr(Q2, 32'h0);
    wr(DEC, 32'h0001_0000);
    rd(DEC, 32'h0, "R7 cleared again");

    // R3 pointer wrap
    for (int i = 0; i < 7; i++) begin
      msg(2'(i % 4), 1'(i % 2));
      msg(2'((i + 1) % 4), 1'((i + 1) % 2));
      rd(Q1, word1(2'(i % 4), 1'(i % 2)), "R3 wrap head");
      wr(Q1, 32'h0);
      rd(Q1, word1(2'((i + 1) % 4), 1'((i + 1) % 2)), "R3 wrap next");
      wr(Q2, 32'h0);
    end
    rd(PRT, 32'h0, "R3 drained after wrap");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule